// File: doc/BRIEF.md
# Banked Scratchpad Group Read Scheduler

This block serves one group of parallel read requests against a scratchpad split into 32 interleaved banks of 32-bit words. Each lane of the group carries a byte address and an active bit. A start strobe captures the group. From then on, every clock cycle is one pass. In each pass every bank performs one read. All pending lanes whose request that read satisfies are completed together. Lanes that want a different word in a bank already in use wait for a later pass. When no lane is left pending, busy drops and the pass counter holds the number of passes the group needed.

Lanes that ask for the same word never conflict with each other. One bank read is broadcast to all of them, and each lane gets back the whole word together with its own byte offset. Only distinct words that fall in the same bank are serialized. Requests from one group are never compared with those of another group. A new group starts only after the current one has finished.

The bank contents are loaded through a write port. It uses a valid/ready handshake. A word is written on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while the block is idle, so a writer that holds `wr_valid` simply stalls until the current group has drained. The start strobe and the status outputs are plain level signals with no handshake.

Top module: `scp_warp_arb`

## Requirements
- R1: A byte address is split into three fields. Bits [1:0] are the byte offset, bits [6:2] the bank and bits [11:7] the row within the bank. Word address w (bits [11:2]) sits in bank w mod 32 at row w/32. A served lane returns the full 32-bit word on its data slot and its byte offset on its offset slot.
- R2: When all active lanes address distinct banks, the group completes in one pass.
- R3: Lanes that address different bytes of one word are served in the same pass from a single bank read.
- R4: When every active lane addresses the identical byte, the group completes in one pass by broadcast.
- R5: The final pass count equals the largest number of distinct words requested from any one bank. The worst case is 32 passes.
- R6: In each pass, every bank serves the word of its lowest-numbered pending lane, together with every other pending lane that requests the same word.
- R7: A lane's done flag rises at the end of the pass that serves it. It stays high until the next accepted start. A start strobe while busy is ignored.
- R8: A start with an all-zero active mask leaves busy low. It clears the done flags and sets the pass count to zero.
- R9: A write is accepted only when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while busy, and an offered write that is not accepted changes no bank. Word address bits [4:0] select the bank and bits [9:5] the row.
- R10: Busy rises only on an accepted start. While busy, the pass count grows by one per cycle. Busy falls right after the last pass.
- R11: Inactive lanes never raise their done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture a request group (ignored while busy) |
| lane_active | input | 32 | Per-lane request enable |
| lane_addr | input | 384 | Per-lane 12-bit byte address, lane i at [12i+11:12i] |
| wr_valid | input | 1 | Preload write offered |
| wr_ready | output | 1 | Preload write can be accepted (idle) |
| wr_addr | input | 10 | Preload word address |
| wr_data | input | 32 | Preload word |
| busy | output | 1 | Group in progress |
| lane_done | output | 32 | Per-lane served flag |
| lane_data | output | 1024 | Per-lane returned word, lane i at [32i+31:32i] |
| lane_ofs | output | 64 | Per-lane byte offset, lane i at [2i+1:2i] |
| pass_count | output | 6 | Passes used by the current or last group |

## Verification
The bound checker watches four things on every cycle:
- done flags never drop during a group;
- every pass completes at least one lane;
- the pass counter steps by exactly one per busy cycle and never exceeds the lane count;
- busy rises only after a start, and outputs hold while idle.

Only the bench scenarios can show the rest:
- that the pass count matches the per-bank distinct-word maximum for strided, broadcast, byte-spread and partial-mask groups;
- that the lowest lane wins each bank;
- that returned words and offsets are correct;
- that starts and writes offered while busy leave no trace.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic {SCP_IDLE = 1'b0, SCP_RUN = 1'b1} scp_state_e;
endpackage

// File: rtl/scp_bank.sv
// One bank of the scratchpad: single write port, combinational read.
module scp_bank #(
  parameter int ROWS   = 32,
  parameter int WORD_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ROW_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scp_pick.sv
// Per-bank selector: row requested by the lowest-numbered pending lane
// that maps to this bank.
module scp_pick #(
  parameter int LANES   = 32,
  parameter int BANK_W  = 5,
  parameter int ROW_W   = 5,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
  input  logic [LANES-1:0][ROW_W-1:0]  lane_row,
  output logic [ROW_W-1:0]             row_sel
);
  always_comb begin
    row_sel = '0;
    // walk downward so the lowest matching lane is assigned last
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i] && (lane_bank[i] == BANK_W'(BANK_ID))) row_sel = lane_row[i];
    end
  end
endmodule

// File: rtl/scp_warp_arb.sv
module scp_warp_arb #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic [LANES-1:0]                         lane_active,
  input  logic [LANES*ADDR_W-1:0]                  lane_addr,
  input  logic                                     wr_valid,
  output logic                                     wr_ready,
  input  logic [ADDR_W-$clog2(WORD_W/8)-1:0]       wr_addr,
  input  logic [WORD_W-1:0]                        wr_data,
  output logic                                     busy,
  output logic [LANES-1:0]                         lane_done,
  output logic [LANES*WORD_W-1:0]                  lane_data,
  output logic [LANES*$clog2(WORD_W/8)-1:0]        lane_ofs,
  output logic [$clog2(LANES+1)-1:0]               pass_count
);
  import scp_pkg::*;

  localparam int OFS_W  = $clog2(WORD_W / 8);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - OFS_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int CNT_W  = $clog2(LANES + 1);

  scp_state_e                        state_q;
  logic [LANES-1:0]                  pending_q;
  logic [LANES-1:0]                  done_q;
  logic [LANES-1:0][ADDR_W-1:0]      addr_q;
  logic [LANES-1:0][WORD_W-1:0]      data_q;
  logic [CNT_W-1:0]                  pass_q;

  logic [LANES-1:0][BANK_W-1:0]      lane_bank;
  logic [LANES-1:0][ROW_W-1:0]       lane_row;
  logic [BANKS-1:0][ROW_W-1:0]       row_sel;
  logic [BANKS-1:0][WORD_W-1:0]      bank_rd;
  logic [LANES-1:0]                  served;
  logic [LANES-1:0]                  left;
  logic                              wr_fire;

  assign wr_ready = (state_q == SCP_IDLE);
  assign wr_fire  = wr_valid && wr_ready;

  // field split of each captured byte address
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bank[l] = addr_q[l][OFS_W +: BANK_W];
    assign lane_row[l]  = addr_q[l][OFS_W + BANK_W +: ROW_W];
    assign lane_ofs[l*OFS_W +: OFS_W]    = addr_q[l][OFS_W-1:0];
    assign lane_data[l*WORD_W +: WORD_W] = data_q[l];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    scp_pick #(
      .LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W), .BANK_ID(b)
    ) u_pick (
      .pending  (pending_q),
      .lane_bank(lane_bank),
      .lane_row (lane_row),
      .row_sel  (row_sel[b])
    );

    scp_bank #(.ROWS(ROWS), .WORD_W(WORD_W)) u_bank (
      .clk  (clk),
      .we   (wr_fire && (wr_addr[BANK_W-1:0] == BANK_W'(b))),
      .waddr(wr_addr[BANK_W +: ROW_W]),
      .wdata(wr_data),
      .raddr(row_sel[b]),
      .rdata(bank_rd[b])
    );
  end

  // a pending lane is served when its bank reads the row it asked for
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      served[i] = pending_q[i] && (lane_row[i] == row_sel[lane_bank[i]]);
    end
    left = pending_q & ~served;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SCP_IDLE;
      pending_q <= '0;
      done_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      pass_q    <= '0;
    end else begin
      unique case (state_q)
        SCP_IDLE: begin
          if (start) begin
            addr_q    <= lane_addr;
            pending_q <= lane_active;
            done_q    <= '0;
            pass_q    <= '0;
            state_q   <= (|lane_active) ? SCP_RUN : SCP_IDLE;
          end
        end
        SCP_RUN: begin
          for (int i = 0; i < LANES; i++) begin
            if (served[i]) data_q[i] <= bank_rd[lane_bank[i]];
          end
          done_q    <= done_q | served;
          pending_q <= left;
          pass_q    <= pass_q + 1'b1;
          if (left == '0) state_q <= SCP_IDLE;
        end
        default: state_q <= SCP_IDLE;
      endcase
    end
  end

  assign busy       = (state_q == SCP_RUN);
  assign lane_done  = done_q;
  assign pass_count = pass_q;
endmodule

// File: rtl/scp_warp_arb_chk.sv
module scp_warp_arb_chk #(
  parameter int LANES = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [LANES-1:0] lane_done,
  input logic [CNT_W-1:0] pass_count
);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((lane_done & $past(lane_done)) == $past(lane_done)));

  // R6
  pass_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($countones(lane_done) > $countones($past(lane_done))));

  // R10
  pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (pass_count == $past(pass_count) + 1'b1));

  // R10
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_count <= CNT_W'(LANES));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(lane_done) && $stable(pass_count)));
endmodule

bind scp_warp_arb scp_warp_arb_chk #(
  .LANES(LANES), .CNT_W($clog2(LANES + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .lane_done(lane_done), .pass_count(pass_count)
);

// File: tb/tb_scp_warp_arb.sv
`timescale 1ns/1ps
module tb_scp_warp_arb;
  localparam int LANES = 32;
  localparam int AW    = 12;
  localparam int WORDS = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [LANES-1:0]  lane_active = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [9:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              busy;
  logic [LANES-1:0]  lane_done;
  logic [LANES*32-1:0] lane_data;
  logic [LANES*2-1:0]  lane_ofs;
  logic [5:0]        pass_count;

  int tests = 0;
  int fails = 0;
  int cyc;

  always #2.5 clk = ~clk;

  scp_warp_arb dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_active(lane_active),
    .lane_addr(lane_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .lane_done(lane_done),
    .lane_data(lane_data), .lane_ofs(lane_ofs), .pass_count(pass_count)
  );

  typedef struct packed {
    logic [9:0]  base;
    logic [10:0] stride;
    logic        spread;
    logic [31:0] mask;
    logic [6:0]  passes;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{10'd0, 11'd1,  1'b0, 32'hFFFF_FFFF, 7'd1},   // R2 consecutive words
    '{10'd5, 11'd3,  1'b1, 32'hFFFF_FFFF, 7'd1},   // R2 odd stride
    '{10'd0, 11'd2,  1'b0, 32'hFFFF_FFFF, 7'd2},   // R5
    '{10'd0, 11'd4,  1'b0, 32'hFFFF_FFFF, 7'd4},   // R5
    '{10'd0, 11'd16, 1'b0, 32'hFFFF_FFFF, 7'd16},  // R5
    '{10'd0, 11'd32, 1'b0, 32'hFFFF_FFFF, 7'd32},  // R5 worst case
    '{10'd7, 11'd0,  1'b0, 32'hFFFF_FFFF, 7'd1},   // R4 broadcast
    '{10'd9, 11'd0,  1'b1, 32'hFFFF_FFFF, 7'd1},   // R3 bytes of one word
    '{10'd0, 11'd32, 1'b0, 32'h0000_000F, 7'd4},   // R11 partial mask
    '{10'd3, 11'd32, 1'b0, 32'hAAAA_AAAA, 7'd16}   // R11 odd lanes only
  };

  function automatic logic [31:0] word_val(input int w);
    return 32'hC0DE_0000 ^ (32'(w) * 32'h0001_9E37);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_word(input int w, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 10'(w); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // pulse start, then count busy cycles (one per pass)
  task automatic run_group(input logic [LANES-1:0] m, input logic [LANES*AW-1:0] a);
    @(negedge clk);
    start = 1'b1; lane_active = m; lane_addr = a;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int w, input int byt);
    return AW'(((w % WORDS) * 4) + byt);
  endfunction

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [LANES*AW-1:0] a;
    logic [31:0] old0;
    int bad;
    logic [31:0] bad_act, bad_exp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 1'b0 && lane_done == '0, "R10", {busy, lane_done}, 0);
    check(pass_count == 0, "R10", pass_count, 0);
    check(wr_ready == 1'b1, "R9", wr_ready, 1);

    // preload the whole scratchpad through the handshake port
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 10'(w); wr_data = word_val(w);
    end
    @(negedge clk);
    wr_valid = 1'b0;

    // table walk
    for (int v = 0; v < 10; v++) begin
      int bw;
      int by;
      for (int i = 0; i < LANES; i++) begin
        bw = (int'(VECS[v].base) + int'(VECS[v].stride) * i) % WORDS;
        by = VECS[v].spread ? (i % 4) : 0;
        a[i*AW +: AW] = mk_addr(bw, by);
      end
      run_group(VECS[v].mask, a);
      check(pass_count == 6'(VECS[v].passes), (v == 6) ? "R4" : (v == 7) ? "R3" : (v < 2) ? "R2" : "R5",
            pass_count, VECS[v].passes);
      check(cyc == int'(VECS[v].passes), "R10", cyc, VECS[v].passes);
      check(lane_done == VECS[v].mask, "R11", lane_done, VECS[v].mask);
      bad = 0; bad_act = 0; bad_exp = 0;
      for (int i = 0; i < LANES; i++) begin
        if (VECS[v].mask[i]) begin
          bw = (int'(VECS[v].base) + int'(VECS[v].stride) * i) % WORDS;
          by = VECS[v].spread ? (i % 4) : 0;
          if (lane_data[i*32 +: 32] != word_val(bw) || lane_ofs[i*2 +: 2] != 2'(by)) begin
            if (bad == 0) begin bad_act = lane_data[i*32 +: 32]; bad_exp = word_val(bw); end
            bad++;
          end
        end
      end
      check(bad == 0, "R1", bad_act, bad_exp);
    end

    // R6: lanes 0 and 2 want word 32, lane 1 wants word 0, all bank 0
    a = '0;
    a[0*AW +: AW] = mk_addr(32, 1);
    a[1*AW +: AW] = mk_addr(0, 0);
    a[2*AW +: AW] = mk_addr(32, 3);
    @(negedge clk);
    start = 1'b1; lane_active = 32'h7; lane_addr = a;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(lane_done == 32'h5, "R6", lane_done, 32'h5);
    @(negedge clk);
    check(lane_done == 32'h7 && !busy, "R6", lane_done, 32'h7);
    check(lane_data[2*32 +: 32] == word_val(32) && lane_ofs[2*2 +: 2] == 2'd3, "R3",
          lane_data[2*32 +: 32], word_val(32));

    // R7 / R9: start and write offered while busy are ignored
    old0 = word_val(0);
    for (int i = 0; i < LANES; i++) a[i*AW +: AW] = mk_addr(32 * i, 0);
    @(negedge clk);
    start = 1'b1; lane_active = '1; lane_addr = a;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; lane_active = 32'h1; lane_addr = '0;
    wr_valid = 1'b1; wr_addr = 10'd0; wr_data = 32'hDEAD_BEEF;
    check(wr_ready == 1'b0, "R9", wr_ready, 0);
    @(negedge clk);
    start = 1'b0; wr_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin @(negedge clk); cyc++; end
    check(pass_count == 6'd32 && lane_done == '1, "R7", pass_count, 32);
    repeat (5) @(negedge clk);
    check(lane_done == '1 && pass_count == 6'd32, "R7", lane_done, 32'hFFFF_FFFF);

    // the refused write left word 0 untouched
    a = '0;
    run_group(32'h1, a);
    check(lane_data[31:0] == old0, "R9", lane_data[31:0], old0);
    // an accepted write is visible
    write_word(0, 32'h1234_5678);
    run_group(32'h1, a);
    check(lane_data[31:0] == 32'h1234_5678, "R9", lane_data[31:0], 32'h1234_5678);

    // R8: empty mask
    @(negedge clk);
    start = 1'b1; lane_active = '0; lane_addr = '0;
    @(negedge clk);
    start = 1'b0;
    check(!busy && pass_count == 0 && lane_done == '0, "R8", {busy, pass_count}, 0);
    @(negedge clk);
    check(!busy, "R8", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule